// File: doc/BRIEF.md
# Multi-Slope Exposure Reset Sequencer

This block drives the pixel reset controls of a global-shutter image sensor over one exposure. When a frame start arrives while the block is idle, it opens an integration window of programmable length. A main reset pulse is issued at the beginning of the window. Up to `NSEC` secondary resets follow inside the window. Each secondary reset lowers the reset level one step further, which gives the pixel a multi-slope response curve. A binary level index tells the analog side which lower level to apply. A main reset and a secondary reset can be requested in the same cycle. In that case the main reset wins, because the higher level must be applied.

Each secondary slot has its own start offset and width, in clock cycles counted from the first cycle of integration. A slot that would run past the end of the window is not issued, and a sticky error flag records that this happened. After integration, the block can run in two ways. In sequential mode it starts readout and then waits for the next frame start. In parallel mode it starts readout of the frame just exposed and, in the same cycle, begins integrating the next frame.

Top module: `exposure_reset_seq`

## Requirements
- R1: While reset is applied, and in idle after reset, every output is low (level index zero, error flag clear).
- R2: A frame start seen while idle makes the integration-active output rise in the next cycle, and it stays high for exactly `int_len` cycles (cycle index t = 0 .. int_len-1); a value of zero acts as one.
- R3: The main reset output is high in integration cycles t < `main_w` and low otherwise.
- R4: Secondary slot k (zero-based, k < `sec_num`) occupies bits [k*CW +: CW] of `sec_off` and `sec_wid`. When it fits (off_k + wid_k <= int_len) and its width is non-zero, it requests the secondary reset in cycles off_k <= t < off_k + wid_k. Slots at or above `sec_num` never request.
- R5: Whenever the main reset is high, the secondary reset output is low, even if a slot requests it.
- R6: During integration the level index equals the number of eligible slots (fitting, non-zero width, k < `sec_num`) whose offset is <= t. Outside integration it is zero, so each main reset starts again from zero.
- R7: A slot with k < `sec_num` and off_k + wid_k > int_len is never issued and is not counted in the level index. The error flag goes high one cycle after the first integration cycle of that exposure and stays high until reset.
- R8: With the parallel-mode input low during the last integration cycle, the readout-start output pulses for one cycle in the next cycle, integration is inactive in that cycle, and the block then returns to idle.
- R9: With the parallel-mode input high during the last integration cycle, in the next cycle readout start pulses and a new integration begins together (t = 0, main reset applied).
- R10: A frame start received while an exposure or readout start is in progress is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Starts an exposure when idle |
| par_mode | input | 1 | Parallel operation, sampled in the last integration cycle |
| int_len | input | CW | Integration length in cycles |
| main_w | input | CW | Main reset width in cycles |
| sec_num | input | LW | Number of active secondary slots (0..NSEC) |
| sec_off | input | NSEC*CW | Start offsets of the secondary slots |
| sec_wid | input | NSEC*CW | Widths of the secondary slots |
| rst_main_o | output | 1 | Main reset pulse |
| rst_sec_o | output | 1 | Secondary (lower-level) reset pulse |
| lvl_o | output | LW | Reset level index for the secondary reset |
| int_act_o | output | 1 | Integration in progress |
| ro_start_o | output | 1 | One-cycle readout start |
| sched_err_o | output | 1 | Sticky flag: a secondary slot did not fit |

## Verification
The bench builds the block with `NSEC = 3` and `CW = 8`. With these values the full range of `sec_num`, including all three slots, takes only a few dozen cycles per exposure. A window as short as one cycle and slots that end exactly on the window boundary are also reachable. Three slots are enough to mix an active slot, one with zero width, one that overlaps the main pulse and one that does not fit in a single exposure. The 8-bit counter keeps parallel runs of two back-to-back exposures short enough to compare every output on every cycle.

// File: rtl/exr_pkg.sv
package exr_pkg;
  typedef enum logic [1:0] {
    EXR_IDLE = 2'd0,
    EXR_INT  = 2'd1,
    EXR_RO   = 2'd2
  } exr_state_e;
endpackage

// File: rtl/exr_rst_sync.sv
module exr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/exr_timer.sv
module exr_timer
  import exr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          par_mode,
  input  logic [CW-1:0] int_len,
  output logic [CW-1:0] tcnt,
  output logic          int_act,
  output logic          ro_start,
  output logic          last_cyc
);
  exr_state_e    st_q, st_d;
  logic [CW-1:0] t_q, t_d;
  logic          ro_q, ro_d;
  logic          t_en;
  logic [CW:0]   t_plus;

  assign t_plus   = {1'b0, t_q} + {{CW{1'b0}}, 1'b1};
  assign last_cyc = (st_q == EXR_INT) && (t_plus >= {1'b0, int_len});
  assign t_en     = (st_q != EXR_IDLE) || frame_start;

  always_comb begin
    st_d = st_q;
    t_d  = t_q;
    ro_d = 1'b0;
    unique case (st_q)
      EXR_IDLE: begin
        if (frame_start) begin
          st_d = EXR_INT;
          t_d  = '0;
        end
      end
      EXR_INT: begin
        if (last_cyc) begin
          ro_d = 1'b1;
          t_d  = '0;
          st_d = par_mode ? EXR_INT : EXR_RO;
        end else begin
          t_d  = t_plus[CW-1:0];
        end
      end
      EXR_RO:   st_d = EXR_IDLE;
      default:  st_d = EXR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= EXR_IDLE;
      ro_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ro_q <= ro_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    t_q <= '0;
    else if (t_en) t_q <= t_d;
  end

  assign tcnt     = t_q;
  assign int_act  = (st_q == EXR_INT);
  assign ro_start = ro_q;

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == EXR_IDLE && frame_start) |=> (int_act && tcnt == '0));
  a_r8_seq_readout: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && !par_mode) |=> (ro_start && !int_act));
  a_r9_par_readout: assert property (@(posedge clk) disable iff (!rst_n)
    (last_cyc && par_mode) |=> (ro_start && int_act && tcnt == '0));
  a_r10_busy_step: assert property (@(posedge clk) disable iff (!rst_n)
    (int_act && !last_cyc) |=> (int_act && tcnt == CW'($past(tcnt) + 1'b1)));
endmodule

// File: rtl/exr_slot.sv
module exr_slot #(
  parameter int CW = 16
) (
  input  logic          en,
  input  logic          int_act,
  input  logic [CW-1:0] tcnt,
  input  logic [CW-1:0] int_len,
  input  logic [CW-1:0] off,
  input  logic [CW-1:0] wid,
  output logic          hit,
  output logic          started,
  output logic          drop
);
  logic [CW:0] end_x;
  logic        fits, elig;

  assign end_x   = {1'b0, off} + {1'b0, wid};
  assign fits    = end_x <= {1'b0, int_len};
  assign drop    = en && !fits;
  assign elig    = en && fits && (wid != '0);
  assign started = int_act && elig && (tcnt >= off);
  assign hit     = started && ({1'b0, tcnt} < end_x);
endmodule

// File: rtl/exposure_reset_seq.sv
module exposure_reset_seq
  import exr_pkg::*;
#(
  parameter  int NSEC = 4,
  parameter  int CW   = 16,
  localparam int LW   = $clog2(NSEC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               par_mode,
  input  logic [CW-1:0]      int_len,
  input  logic [CW-1:0]      main_w,
  input  logic [LW-1:0]      sec_num,
  input  logic [NSEC*CW-1:0] sec_off,
  input  logic [NSEC*CW-1:0] sec_wid,
  output logic               rst_main_o,
  output logic               rst_sec_o,
  output logic [LW-1:0]      lvl_o,
  output logic               int_act_o,
  output logic               ro_start_o,
  output logic               sched_err_o
);
  logic            srst_n;
  logic [CW-1:0]   tcnt;
  logic            int_act, ro_start, last_cyc;
  logic [NSEC-1:0] en_v, hit_v, started_v, drop_v;
  logic            main_on, err_q, err_set;
  logic [LW-1:0]   lvl;

  exr_rst_sync u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  exr_timer #(.CW(CW)) u_timer (
    .clk         (clk),
    .rst_n       (srst_n),
    .frame_start (frame_start),
    .par_mode    (par_mode),
    .int_len     (int_len),
    .tcnt        (tcnt),
    .int_act     (int_act),
    .ro_start    (ro_start),
    .last_cyc    (last_cyc)
  );

  for (genvar g = 0; g < NSEC; g++) begin : g_slot
    assign en_v[g] = (int'(sec_num) > g);
    exr_slot #(.CW(CW)) u_slot (
      .en      (en_v[g]),
      .int_act (int_act),
      .tcnt    (tcnt),
      .int_len (int_len),
      .off     (sec_off[g*CW +: CW]),
      .wid     (sec_wid[g*CW +: CW]),
      .hit     (hit_v[g]),
      .started (started_v[g]),
      .drop    (drop_v[g])
    );
  end

  assign main_on = int_act && (tcnt < main_w);

  always_comb begin
    lvl = '0;
    for (int i = 0; i < NSEC; i++) lvl = lvl + LW'(started_v[i]);
  end

  assign err_set = int_act && (tcnt == '0) && (|drop_v);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  assign rst_main_o  = main_on;
  assign rst_sec_o   = (|hit_v) && !main_on;
  assign lvl_o       = lvl;
  assign int_act_o   = int_act;
  assign ro_start_o  = ro_start;
  assign sched_err_o = err_q;

  a_r3_main_at_start: assert property (@(posedge clk) disable iff (!srst_n)
    (int_act && tcnt == '0 && main_w != '0) |-> rst_main_o);
  a_r4_sec_in_window: assert property (@(posedge clk) disable iff (!srst_n)
    rst_sec_o |-> int_act_o);
  a_r5_main_wins: assert property (@(posedge clk) disable iff (!srst_n)
    rst_main_o |-> !rst_sec_o);
  a_r6_lvl_idle_zero: assert property (@(posedge clk) disable iff (!srst_n)
    !int_act_o |-> (lvl_o == '0));
  a_r6_lvl_no_fall: assert property (@(posedge clk) disable iff (!srst_n)
    (int_act && !last_cyc) |=> (lvl_o >= $past(lvl_o)));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!srst_n)
    sched_err_o |=> sched_err_o);
endmodule

// File: tb/exposure_reset_seq_test.sv
module exposure_reset_seq_test;
  localparam int NSEC   = 3;
  localparam int CW     = 8;
  localparam int LW     = $clog2(NSEC + 1);
  localparam time TCLK  = 10ns;
  localparam int NV     = 6;
  // fields: int_len, main_w, sec_num, off0, off1, off2, wid0, wid1, wid2, parallel
  localparam int VT [NV][10] = '{
    '{12, 3, 2, 5, 8, 0, 2, 3, 0, 0},
    '{10, 2, 3, 1, 4, 7, 3, 2, 3, 0},
    '{ 8, 2, 1, 3, 0, 0, 2, 0, 0, 1},
    '{ 6, 1, 0, 0, 0, 0, 0, 0, 0, 1},
    '{ 1, 1, 0, 0, 0, 0, 0, 0, 0, 0},
    '{ 9, 4, 3, 2, 5, 6, 0, 2, 3, 0}
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic               frame_start, par_mode;
  logic [CW-1:0]      int_len, main_w;
  logic [LW-1:0]      sec_num;
  logic [NSEC*CW-1:0] sec_off, sec_wid;
  logic               rst_main_o, rst_sec_o, int_act_o, ro_start_o, sched_err_o;
  logic [LW-1:0]      lvl_o;

  int nvec = 0;
  int nbad = 0;
  bit err_exp = 1'b0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  exposure_reset_seq #(.NSEC(NSEC), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .par_mode(par_mode),
    .int_len(int_len), .main_w(main_w), .sec_num(sec_num),
    .sec_off(sec_off), .sec_wid(sec_wid),
    .rst_main_o(rst_main_o), .rst_sec_o(rst_sec_o), .lvl_o(lvl_o),
    .int_act_o(int_act_o), .ro_start_o(ro_start_o), .sched_err_o(sched_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " main"}, int'(rst_main_o), 0);
    chk({tag, " sec"},  int'(rst_sec_o), 0);
    chk({tag, " lvl"},  int'(lvl_o), 0);
    chk({tag, " int"},  int'(int_act_o), 0);
    chk({tag, " ro"},   int'(ro_start_o), 0);
    chk({tag, " err"},  int'(sched_err_o), int'(err_exp));
  endtask

  task automatic run_exp(input int L, input int mw, input int num,
                         input int o0, input int o1, input int o2,
                         input int w0, input int w1, input int w2,
                         input int par, input bit fs_mid, input bit drops);
    int offs[3];
    int wids[3];
    int per;
    offs = '{o0, o1, o2};
    wids = '{w0, w1, w2};
    per  = (par != 0) ? 2 : 1;
    @(negedge clk);
    int_len = CW'(L); main_w = CW'(mw); sec_num = LW'(num);
    for (int k = 0; k < NSEC; k++) begin
      sec_off[k*CW +: CW] = CW'(offs[k]);
      sec_wid[k*CW +: CW] = CW'(wids[k]);
    end
    par_mode = (par != 0);
    frame_start = 1'b1;
    @(negedge clk);
    for (int c = 0; c < per*L + 2; c++) begin
      int t, lv;
      bit ia, mn, sc, ro;
      t  = c % L;
      ia = (c < per*L);
      mn = ia && (t < mw);
      sc = 1'b0;
      lv = 0;
      for (int k = 0; k < num; k++) begin
        if (wids[k] != 0 && offs[k] + wids[k] <= L && ia) begin
          if (offs[k] <= t) lv++;
          if (offs[k] <= t && t < offs[k] + wids[k]) sc = 1'b1;
        end
      end
      ro = (c > 0) && (c % L == 0) && (c <= per*L);
      chk(fs_mid ? "R10 int_act" : "R2 int_act", int'(int_act_o), int'(ia));
      chk("R3 main", int'(rst_main_o), int'(mn));
      chk(mn ? "R5 sec" : (drops ? "R7 sec" : "R4 sec"), int'(rst_sec_o), int'(sc && !mn));
      chk(drops ? "R7 lvl" : "R6 lvl", int'(lvl_o), lv);
      chk((par != 0) ? "R9 ro" : "R8 ro", int'(ro_start_o), int'(ro));
      chk("R7 err", int'(sched_err_o), int'(err_exp || (drops && c >= 1)));
      frame_start = fs_mid && (c == 2);
      par_mode    = (par != 0) && (c + 1 < 2*L - 1);
      @(negedge clk);
    end
    frame_start = 1'b0;
    par_mode    = 1'b0;
    if (drops) err_exp = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; par_mode = 1'b0;
    int_len = '0; main_w = '0; sec_num = '0; sec_off = '0; sec_wid = '0;
    repeat (3) @(negedge clk);
    chk_quiet("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_quiet("R1 after reset");

    for (int i = 0; i < NV; i++)
      run_exp(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], VT[i][5],
              VT[i][6], VT[i][7], VT[i][8], VT[i][9], 1'b0, 1'b0);

    // R10: frame start during a running exposure
    run_exp(12, 3, 2, 5, 8, 0, 2, 3, 0, 0, 1'b1, 1'b0);
    // R7: second slot overruns the window
    run_exp(8, 1, 2, 2, 6, 0, 2, 4, 0, 0, 1'b0, 1'b1);
    // R7: flag stays set through a clean exposure
    run_exp(10, 2, 1, 4, 0, 0, 3, 0, 0, 0, 1'b0, 1'b0);
    // R4: slot exactly reaching the window end, slot 2 masked by sec_num
    run_exp(7, 1, 2, 3, 5, 1, 1, 2, 6, 0, 1'b0, 1'b0);

    @(negedge clk);
    rst_n = 1'b0;
    err_exp = 1'b0;
    @(negedge clk);
    chk_quiet("R1 reset clears");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_quiet("R1 idle again");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule